// File: doc/BRIEF.md
# Four-Channel Paddle Charge-Time Sampler

This block measures four analog paddle lines by timing how long each one takes to charge. A measurement has two halves. First, all four lines are held at ground through an external open-drain pull-down for 2**CNT_W slow-clock cycles (256 by default). Then the pull-down is released for the same number of cycles, and each line charges through its external resistor. An external comparator on every line flags the moment the line crosses its threshold, and the block records the slow-cycle count at that moment. The slow clock is a one-cycle enable pulse, `phi2_en`, on the fast clock `clk`. Measurements start by themselves after reset and repeat without a break.

All four channels are measured at the same time, whatever the select input says. The two control ports each own a pair of channels. A 2-bit select code, taken from the surrounding I/O port configuration, chooses which pair the two readable result registers return.

Reads are a plain combinational lookup with no handshake, so there is no back-pressure. `rd_data` follows `rd_addr` in the same cycle. It follows a new select code one `clk` edge after that code is applied. The comparator inputs are taken to be synchronous to `clk`.

Top module: `paddle_sampler`

## Requirements
- R1: After reset, `discharge_n` is 0 (discharging) and every result register reads 0 for both port selections. The reset selection is port 1.
- R2: `discharge_n` stays 0 for 256 `phi2_en` pulses, then stays 1 for 256 pulses, and this repeats. It changes only at the clock edge of the 256th pulse of a phase.
- R3: The phase count moves only on `clk` edges where `phi2_en` is 1. Any number of edges without it changes neither `discharge_n` nor any result.
- R4: Charge-phase pulses are numbered k = 0 to 255. A channel's result is the k of the first charge pulse in which its `cmp_hi` bit is 1. The bit dropping back to 0 later in the same phase has no effect.
- R5: A channel whose `cmp_hi` bit is never 1 during the charge phase reports 255.
- R6: `cmp_hi` values during the discharge phase do not affect the results.
- R7: All four results update together, only at the edge of the last charge-phase pulse. Between those edges the readable values stay fixed.
- R8: The select code `port_sel` = 01 picks port 1, and `rd_addr` 0 and 1 then return channels 0 and 1. The code 10 picks port 2, returning channels 2 and 3. The codes 00 and 11 keep the previous selection.
- R9: The selection only steers reads. Results for all four channels are produced every measurement whatever the select code was during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phi2_en | input | 1 | One-`clk` pulse marking each slow cycle |
| cmp_hi | input | 4 | Comparator outputs, 1 = line above threshold, bit i = channel i |
| port_sel | input | 2 | Port select code: 01 = port 1, 10 = port 2, other codes hold the selection |
| rd_addr | input | 1 | Selects the first (0) or second (1) result of the selected pair |
| discharge_n | output | 1 | Active-low enable for the open-drain pull-down on all four lines |
| rd_data | output | 8 | Result for the selected port and address |

## Verification
The bench holds each input for one `clk` edge with `phi2_en` high, then one idle edge. The comparator value applied for charge pulse k is therefore sampled at that pulse's edge. The bench checks `discharge_n` just before every pulse, so it sees the phase flip exactly one edge after pulse 255 of a phase. New results are due at the edge of charge pulse 255. They are read only afterwards, with one edge allowed after every select change. A mid-phase read at charge pulse 200 must still return the previous measurement's values.

// File: rtl/paddle_pkg.sv
package paddle_pkg;
  typedef enum logic {
    PH_DISCH  = 1'b0,
    PH_CHARGE = 1'b1
  } phase_t;
endpackage

// File: rtl/paddle_seq.sv
module paddle_seq
  import paddle_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phi2_en,
  output logic [CNT_W-1:0] cnt,
  output logic             step,
  output logic             frame_done,
  output logic             discharge_n
);
  localparam logic [CNT_W-1:0] LAST = '1;

  phase_t     phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_DISCH;
      cnt_q   <= '0;
    end else if (phi2_en) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST)
        phase_q <= (phase_q == PH_DISCH) ? PH_CHARGE : PH_DISCH;
    end
  end

  assign cnt         = cnt_q;
  assign step        = phi2_en && (phase_q == PH_CHARGE);
  assign frame_done  = step && (cnt_q == LAST);
  assign discharge_n = (phase_q == PH_CHARGE);
endmodule

// File: rtl/paddle_chan.sv
module paddle_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp,
  input  logic             step,
  input  logic             frame_done,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] result
);
  localparam logic [CNT_W-1:0] NO_HIT = '1;

  logic             hit_q;
  logic [CNT_W-1:0] val_q;
  logic [CNT_W-1:0] res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      val_q <= '0;
      res_q <= '0;
    end else if (frame_done) begin
      res_q <= hit_q ? val_q : NO_HIT;
      hit_q <= 1'b0;
    end else if (step && !hit_q && cmp) begin
      hit_q <= 1'b1;
      val_q <= cnt;
    end
  end

  assign result = res_q;
endmodule

// File: rtl/paddle_rdmux.sv
module paddle_rdmux #(
  parameter int CNT_W  = 8,
  parameter int PAIR   = 2,
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              port_sel,
  input  logic [$clog2(PAIR)-1:0] rd_addr,
  input  logic [NUM_CH*CNT_W-1:0] res_flat,
  output logic                    sel_o,
  output logic [CNT_W-1:0]        rd_data
);
  logic sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  sel_q <= 1'b0;
    else if (port_sel == 2'b01)  sel_q <= 1'b0;
    else if (port_sel == 2'b10)  sel_q <= 1'b1;
  end

  always_comb begin
    int idx;
    idx     = int'(sel_q) * PAIR + int'(rd_addr);
    rd_data = res_flat[idx*CNT_W +: CNT_W];
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/paddle_sampler.sv
module paddle_sampler #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phi2_en,
  input  logic [3:0]       cmp_hi,
  input  logic [1:0]       port_sel,
  input  logic             rd_addr,
  output logic             discharge_n,
  output logic [CNT_W-1:0] rd_data
);
  localparam int PAIR   = 2;
  localparam int NUM_CH = 2 * PAIR;

  logic [CNT_W-1:0]        cnt;
  logic                    step;
  logic                    frame_done;
  logic [NUM_CH*CNT_W-1:0] res_flat;
  logic                    sel_q;

  paddle_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .phi2_en(phi2_en), .cnt(cnt),
    .step(step), .frame_done(frame_done), .discharge_n(discharge_n)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    paddle_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .cmp(cmp_hi[i]), .step(step),
      .frame_done(frame_done), .cnt(cnt),
      .result(res_flat[i*CNT_W +: CNT_W])
    );
  end

  paddle_rdmux #(.CNT_W(CNT_W), .PAIR(PAIR), .NUM_CH(NUM_CH)) u_rd (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .rd_addr(rd_addr),
    .res_flat(res_flat), .sel_o(sel_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/paddle_sampler_chk.sv
module paddle_sampler_chk #(
  parameter int CNT_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               phi2_en,
  input logic [1:0]         port_sel,
  input logic               discharge_n,
  input logic [CNT_W-1:0]   cnt,
  input logic [4*CNT_W-1:0] res_flat,
  input logic               sel_q
);
  localparam logic [CNT_W-1:0] LAST = '1;

  // R3: no slow-cycle pulse, no change of phase or results
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2_en |=> ($stable(discharge_n) && $stable(res_flat)));

  // R2: the phase flips only after the final pulse of a phase
  a_r2_flip_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(discharge_n) |-> ($past(phi2_en) && $past(cnt) == LAST));

  // R7: results change only at the end of a charge phase
  a_r7_update_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_flat) |-> ($past(phi2_en) && $past(cnt) == LAST && $past(discharge_n)));

  // R8: the codes 00 and 11 keep the selection
  a_r8_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
    (port_sel == 2'b00 || port_sel == 2'b11) |=> $stable(sel_q));
endmodule

bind paddle_sampler paddle_sampler_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .phi2_en(phi2_en), .port_sel(port_sel),
  .discharge_n(discharge_n), .cnt(cnt), .res_flat(res_flat), .sel_q(sel_q)
);

// File: tb/paddle_sampler_test.sv
`timescale 1ns/1ps
module paddle_sampler_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phi2_en = 1'b0;
  logic [3:0] cmp_hi = '0;
  logic [1:0] port_sel = 2'b00;
  logic       rd_addr = 1'b0;
  logic       discharge_n;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int prev [4];
  int thr [4];

  always #2.5 clk = ~clk;

  paddle_sampler uut (
    .clk(clk), .rst_n(rst_n), .phi2_en(phi2_en), .cmp_hi(cmp_hi),
    .port_sel(port_sel), .rd_addr(rd_addr), .discharge_n(discharge_n),
    .rd_data(rd_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", tag, act, exp);
    end
  endtask

  // one slow cycle: inputs set at negedge, sampled at the next posedge, then one idle edge
  task automatic pulse(input logic [3:0] c, input logic [1:0] ps,
                       input int exp_dn, input string tag);
    @(negedge clk);
    check(tag, int'(discharge_n), exp_dn);
    phi2_en  = 1'b1;
    cmp_hi   = c;
    port_sel = ps;
    @(negedge clk);
    phi2_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] ps, input logic a, input int exp, input string tag);
    @(negedge clk);
    port_sel = ps;
    rd_addr  = a;
    @(negedge clk);
    check(tag, int'(rd_data), exp);
  endtask

  task automatic measure(input int m, input bit glitch);
    logic [1:0] base;
    logic [3:0] c;
    base = m[0] ? 2'b10 : 2'b01;
    rd_addr = m[1];
    // R6: noisy comparator bits during discharge must not matter
    for (int k = 0; k < 256; k++)
      pulse(4'(k * 7 + m), base, 0, "R2 discharge low");
    for (int k = 0; k < 256; k++) begin
      for (int i = 0; i < 4; i++) begin
        c[i] = (k >= thr[i]);
        if (glitch && k > thr[i] && (k % 3) == 0) c[i] = 1'b0; // R4 first crossing wins
      end
      if (k == 200)
        check("R7 mid-phase hold", int'(rd_data), prev[(m[0] ? 2 : 0) + int'(m[1])]);
      pulse(c, k[0] ? 2'b11 : base, 1, "R2 charge high");
    end
    @(negedge clk);
    check("R2 back to discharge", int'(discharge_n), 0);
    repeat (5) @(negedge clk); // R3: idle edges
    for (int i = 0; i < 4; i++) prev[i] = (thr[i] > 255) ? 255 : thr[i];
    // R9: both ports read, whichever port was selected during the run
    rd(2'b01, 1'b0, prev[0], "R4 R5 R9 ch0");
    rd(2'b00, 1'b1, prev[1], "R8 hold port1 ch1");
    rd(2'b10, 1'b0, prev[2], "R4 R5 R9 ch2");
    rd(2'b11, 1'b1, prev[3], "R8 hold port2 ch3");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) prev[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset discharge", int'(discharge_n), 0);
    check("R1 reset port1 ch0", int'(rd_data), 0);
    rd(2'b00, 1'b1, 0, "R1 reset port1 ch1");
    rd(2'b10, 1'b0, 0, "R1 reset port2 ch2");
    rd(2'b10, 1'b1, 0, "R1 reset port2 ch3");
    for (int m = 0; m < 64; m++) begin
      for (int i = 0; i < 4; i++) thr[i] = 4 * m + i;
      measure(m, m[2]);
    end
    for (int i = 0; i < 4; i++) thr[i] = 256;   // R5 no crossing
    measure(64, 1'b0);
    thr[0] = 0; thr[1] = 255; thr[2] = 256; thr[3] = 128;
    measure(65, 1'b1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule